// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

The block takes five interrupt requests: two external request lines, two timer-overflow flags, and a serial flag pair. The serial receive and transmit flags are ORed into a single source. Each source is allowed through only if its own enable bit is set and the master enable bit is set. Among the sources that are allowed through, the controller picks a winner in two steps. A per-source priority bit splits the sources into a high class and a low class, and a fixed order decides between sources of the same class. The winner's vector address is latched and shown to the CPU until the CPU acknowledges it.

On acknowledge, the controller marks the winner's level as in service. While a low-level routine is in service, only high-level requests are accepted. While a high-level routine is in service, nothing is accepted. A return-from-interrupt pulse closes the innermost open level.

Software reaches the enable and priority registers through a byte-wide write/read port. Timers, serial logic, pin conditioning and the CPU sit outside the block.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset, both registers read 0, no vector is pending, no strobe is issued, and neither level is in service.
- R2: `cfg_sel`=0 selects the enable register and `cfg_sel`=1 selects the priority register. A write stores the byte and `cfg_rdata` returns it. In the enable register only bits 0-4 and bit 7 read back; bits 5 and 6 read 0. In the priority register only bits 0-4 read back.
- R3: While enable bit 7 (master enable) is 0, no vector is raised, whatever the per-source enable bits are.
- R4: Enable bits 0..4 gate, in order, external 0 (`src_req[0]`), timer 0 (`src_req[1]`), external 1 (`src_req[2]`), timer 1 (`src_req[3]`) and serial. The serial source is requested when either `ser_rx_flag` or `ser_tx_flag` is 1.
- R5: Among pending requests of the same class, the lowest source index wins.
- R6: Priority bit i = 1 puts source i in the high class. A pending high-class request wins over any pending low-class request, whatever their indices.
- R7: The vector for source i is 0x03 + 8·i. `vec_stb` is high for exactly one cycle when a vector is latched. `vec_pend` and `vec_addr` hold steady until `vec_ack` is sampled high.
- R8: While a low-level routine is in service, a high-class request is accepted and a low-class request waits.
- R9: While a high-level routine is in service, no request of either class is accepted.
- R10: A `reti` pulse clears the high in-service flag if it is set, and otherwise clears the low flag. After a nested high routine returns, the low routine is still in service.
- R11: Writing only bits 5 and 6 of the enable register, together with the master bit, enables no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 priority |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 4 | Requests: external 0, timer 0, external 1, timer 1 |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| vec_stb | output | 1 | One-cycle pulse when a new vector is latched |
| vec_pend | output | 1 | A vector awaits acknowledge |
| vec_addr | output | 8 | Latched vector address |
| vec_ack | input | 1 | CPU acknowledge of the pending vector |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
The hardest state to reach is the nested one: a low routine in service with a high routine stacked on top, followed by a return that must close only the high level. The stimulus builds this state step by step. It acknowledges a low-class vector and keeps a second low-class request asserted. It then raises a high-class request, acknowledges it, and issues returns one at a time. After each return it checks which class of request is accepted. A behavioural reference model, compared every cycle, tracks the strobe, the pending flag, the vector and the read data throughout this sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } irq_lvl_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int DW      = 8,
   parameter int NSRC    = 5,
   parameter int GLB_BIT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic            sel,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic [NSRC-1:0] en_src,
   output logic [NSRC-1:0] pri_src,
   output logic            glb_en
);
   localparam logic [DW-1:0] SRC_MASK = DW'((1 << NSRC) - 1);
   localparam logic [DW-1:0] EN_MASK  = SRC_MASK | (DW'(1) << GLB_BIT);

   if (GLB_BIT >= DW || NSRC > GLB_BIT) begin : g_bad_layout
      $error("irq_cfg_regs: source bits overlap the master bit or exceed the word");
   end

   logic [DW-1:0] en_q;
   logic [DW-1:0] pri_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
      end else if (we) begin
         if (sel) pri_q <= wdata & SRC_MASK;
         else     en_q  <= wdata & EN_MASK;
      end
   end

   assign rdata   = sel ? pri_q : en_q;
   assign en_src  = en_q[NSRC-1:0];
   assign pri_src = pri_q[NSRC-1:0];
   assign glb_en  = en_q[GLB_BIT];

   AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sel) ##1 (!sel) |-> rdata == ($past(wdata) & EN_MASK)); // R2
   AST_PRI_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel) ##1 (sel) |-> rdata == ($past(wdata) & SRC_MASK)); // R2
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NSRC      = 5,
   parameter bit LSB_FIRST = 1'b1,
   parameter int IW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0] req,
   input  logic [NSRC-1:0] en,
   input  logic [NSRC-1:0] pri,
   input  logic            glb_en,
   input  logic            isr_hi,
   input  logic            isr_lo,
   output logic            win_any,
   output logic            win_hi,
   output logic [IW-1:0]   win_idx
);
   logic [NSRC-1:0] elig;
   logic [NSRC-1:0] elig_hi;
   logic [NSRC-1:0] elig_lo;
   logic [IW-1:0]   idx_hi;
   logic [IW-1:0]   idx_lo;

   for (genvar i = 0; i < NSRC; i++) begin : g_gate
      assign elig[i] = glb_en & en[i] & req[i] & ~isr_hi & (~isr_lo | pri[i]);
   end

   assign elig_hi = elig & pri;
   assign elig_lo = elig & ~pri;

   if (LSB_FIRST) begin : g_scan_lsb
      always_comb begin
         idx_hi = '0;
         idx_lo = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig_hi[i]) idx_hi = IW'(i);
            if (elig_lo[i]) idx_lo = IW'(i);
         end
      end
   end else begin : g_scan_msb
      always_comb begin
         idx_hi = '0;
         idx_lo = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (elig_hi[i]) idx_hi = IW'(i);
            if (elig_lo[i]) idx_lo = IW'(i);
         end
      end
   end

   assign win_hi  = |elig_hi;
   assign win_any = |elig;
   assign win_idx = win_hi ? idx_hi : idx_lo;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic reti,
   output logic isr_hi,
   output logic isr_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_hi <= 1'b0;
         isr_lo <= 1'b0;
      end else begin
         if (reti) begin
            if (isr_hi) isr_hi <= 1'b0;
            else        isr_lo <= 1'b0;
         end
         if (take) begin
            if (take_hi) isr_hi <= 1'b1;
            else         isr_lo <= 1'b1;
         end
      end
   end

   AST_RETI_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      reti && isr_hi && !take |=> !isr_hi && (isr_lo == $past(isr_lo))); // R10
   AST_LOW_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      take && !take_hi |-> !isr_hi && !isr_lo); // R8
   AST_HIGH_TAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      take && take_hi |-> !isr_hi); // R9
endmodule

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl #(
   parameter int DW        = 8,
   parameter int NSRC      = 5,
   parameter int GLB_BIT   = 7,
   parameter int VW        = 8,
   parameter int VEC_BASE  = 3,
   parameter int VEC_STEP  = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_sel,
   input  logic [DW-1:0]   cfg_wdata,
   output logic [DW-1:0]   cfg_rdata,
   input  logic [NSRC-2:0] src_req,
   input  logic            ser_rx_flag,
   input  logic            ser_tx_flag,
   output logic            vec_stb,
   output logic            vec_pend,
   output logic [VW-1:0]   vec_addr,
   input  logic            vec_ack,
   input  logic            reti
);
   import irq_pkg::*;

   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC < 2) begin : g_bad_count
      $error("irq_ctrl_2lvl: at least two sources are required");
   end
   if (VEC_BASE + (NSRC - 1) * VEC_STEP >= (1 << VW)) begin : g_bad_vec
      $error("irq_ctrl_2lvl: vector table does not fit VW bits");
   end

   logic [NSRC-1:0] req_all;
   logic [NSRC-1:0] en_src;
   logic [NSRC-1:0] pri_src;
   logic            glb_en;
   logic            isr_hi;
   logic            isr_lo;
   logic            win_any;
   logic            win_hi;
   logic [IW-1:0]   win_idx;
   logic            take;

   logic            pend_q;
   logic            stb_q;
   logic [VW-1:0]   vec_q;
   irq_lvl_e        lvl_q;

   assign req_all = {ser_rx_flag | ser_tx_flag, src_req};

   irq_cfg_regs #(.DW(DW), .NSRC(NSRC), .GLB_BIT(GLB_BIT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .rdata   (cfg_rdata),
      .en_src  (en_src),
      .pri_src (pri_src),
      .glb_en  (glb_en)
   );

   irq_arbiter #(.NSRC(NSRC), .LSB_FIRST(LSB_FIRST), .IW(IW)) u_arb (
      .req     (req_all),
      .en      (en_src),
      .pri     (pri_src),
      .glb_en  (glb_en),
      .isr_hi  (isr_hi),
      .isr_lo  (isr_lo),
      .win_any (win_any),
      .win_hi  (win_hi),
      .win_idx (win_idx)
   );

   irq_level_track u_lvl (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .take_hi (lvl_q == LVL_HIGH),
      .reti    (reti),
      .isr_hi  (isr_hi),
      .isr_lo  (isr_lo)
   );

   function automatic logic [VW-1:0] vec_of(input logic [IW-1:0] idx);
      return VW'(VEC_BASE + int'(idx) * VEC_STEP);
   endfunction

   assign take = vec_ack & pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         stb_q  <= 1'b0;
         vec_q  <= '0;
         lvl_q  <= LVL_LOW;
      end else begin
         stb_q <= 1'b0;
         if (take) begin
            pend_q <= 1'b0;
         end else if (!pend_q && win_any) begin
            pend_q <= 1'b1;
            stb_q  <= 1'b1;
            vec_q  <= vec_of(win_idx);
            lvl_q  <= win_hi ? LVL_HIGH : LVL_LOW;
         end
      end
   end

   assign vec_stb  = stb_q;
   assign vec_pend = pend_q;
   assign vec_addr = vec_q;

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |=> !vec_stb); // R7
   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      vec_pend && !vec_ack |=> vec_pend && $stable(vec_addr)); // R7
   AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |-> $past(glb_en)); // R3
   AST_HI_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb |-> !$past(isr_hi)); // R9
   AST_LO_NEST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      vec_stb && $past(isr_lo) |-> lvl_q == LVL_HIGH); // R8
endmodule

// File: tb/irq_ctrl_2lvl_bench.sv
module irq_ctrl_2lvl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic [3:0] src_req = 4'h0;
   logic       ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
   logic       vec_stb, vec_pend, vec_ack = 1'b0, reti = 1'b0;
   logic [7:0] vec_addr;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irq_ctrl_2lvl u_irq_ctrl_2lvl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_req(src_req),
      .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
      .vec_stb(vec_stb), .vec_pend(vec_pend), .vec_addr(vec_addr),
      .vec_ack(vec_ack), .reti(reti)
   );

   // Behavioural reference model
   logic [7:0] m_en, m_pr, m_vec;
   bit m_pend, m_stb, m_hi, m_lo, m_lvl;

   function automatic bit m_ok(input int i, input logic [4:0] r);
      return m_en[7] && m_en[i] && r[i] && !m_hi && (!m_lo || m_pr[i]);
   endfunction

   always @(posedge clk) begin
      int pick;
      bit pick_hi;
      logic [4:0] r;
      if (!rst_n) begin
         m_en = 0; m_pr = 0; m_vec = 0;
         m_pend = 0; m_stb = 0; m_hi = 0; m_lo = 0; m_lvl = 0;
      end else begin
         r = {ser_rx_flag | ser_tx_flag, src_req};
         pick = -1; pick_hi = 0;
         for (int i = 0; i < 5; i++)
            if (pick < 0 && m_ok(i, r) && m_pr[i]) begin pick = i; pick_hi = 1; end
         for (int i = 0; i < 5; i++)
            if (pick < 0 && m_ok(i, r) && !m_pr[i]) pick = i;
         m_stb = 0;
         if (reti) begin
            if (m_hi) m_hi = 0; else m_lo = 0;
         end
         if (vec_ack && m_pend) begin
            m_pend = 0;
            if (m_lvl) m_hi = 1; else m_lo = 1;
         end else if (!m_pend && pick >= 0) begin
            m_pend = 1; m_stb = 1; m_lvl = pick_hi;
            m_vec = 8'(3 + 8 * pick);
         end
         if (cfg_we) begin
            if (cfg_sel) m_pr = cfg_wdata & 8'h1F;
            else         m_en = cfg_wdata & 8'h9F;
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7 strobe vs model", 8'(vec_stb), 8'(m_stb));
         chk("R7 pending vs model", 8'(vec_pend), 8'(m_pend));
         if (m_pend) chk("R7 vector vs model", vec_addr, m_vec);
         chk("R2 readback vs model", cfg_rdata, cfg_sel ? m_pr : m_en);
      end
   end

   task automatic cyc();
      @(negedge clk);
      #2;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
      cyc();
      cfg_we = 0;
   endtask

   task automatic ack();
      vec_ack = 1; cyc(); vec_ack = 0;
   endtask

   task automatic ret();
      reti = 1; cyc(); reti = 0;
   endtask

   task automatic expect_vec(input string tag, input logic [7:0] v);
      for (int k = 0; k < 8; k++) begin
         if (vec_pend) break;
         cyc();
      end
      chk(tag, 8'(vec_pend), 8'h01);
      chk(tag, vec_addr, v);
   endtask

   task automatic expect_none(input string tag);
      repeat (4) cyc();
      chk(tag, 8'(vec_pend), 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      // R1 reset state
      chk("R1 pend after reset", 8'(vec_pend), 8'h00);
      chk("R1 strobe after reset", 8'(vec_stb), 8'h00);
      chk("R1 enable reads 0", cfg_rdata, 8'h00);
      cfg_sel = 1; #1;
      chk("R1 priority reads 0", cfg_rdata, 8'h00);
      rst_n = 1; cfg_sel = 0;
      cyc();

      // R2 register access
      wr(0, 8'hFF); chk("R2 enable mask", cfg_rdata, 8'h9F);
      wr(1, 8'hFF); chk("R2 priority mask", cfg_rdata, 8'h1F);
      wr(0, 8'h01); chk("R2 single bit", cfg_rdata, 8'h01);
      wr(1, 8'h00);

      // R11 reserved bits enable nothing
      src_req = 4'hF; ser_rx_flag = 1;
      wr(0, 8'hE0);
      expect_none("R11 reserved bits");
      // R3 master enable off
      wr(0, 8'h1F);
      expect_none("R3 master off");

      // R4 individual gating and serial OR
      wr(0, 8'h84);
      expect_vec("R4 only ext1 enabled", 8'h13);
      ack(); src_req = 0; ser_rx_flag = 0; ret();
      wr(0, 8'h90);
      ser_tx_flag = 1;
      expect_vec("R4 serial via tx", 8'h23);
      ack(); ser_tx_flag = 0; ret();
      ser_rx_flag = 1;
      expect_vec("R4 serial via rx", 8'h23);
      ack(); ser_rx_flag = 0; ret();

      // R5 fixed order, R7 hold
      wr(0, 8'h9F);
      src_req = 4'hF; ser_rx_flag = 1;
      expect_vec("R5 ext0 first", 8'h03);
      repeat (5) cyc();
      chk("R7 held without ack", vec_addr, 8'h03);
      chk("R7 strobe low while held", 8'(vec_stb), 8'h00);
      ack(); src_req[0] = 0; ret();
      expect_vec("R5 timer0 next", 8'h0B);
      ack(); src_req[1] = 0; ret();
      expect_vec("R5 ext1 next", 8'h13);
      ack(); src_req = 0; ser_rx_flag = 0; ret();
      cyc();

      // R6 high class wins, R9 no preempt of high
      wr(1, 8'h10);
      src_req = 4'hF; ser_tx_flag = 1;
      expect_vec("R6 serial high wins", 8'h23);
      ack();
      expect_none("R9 low blocked by high");
      wr(1, 8'h14);
      expect_none("R9 high blocked by high");
      ser_tx_flag = 0; ret();
      expect_vec("R6 ext1 high over ext0 low", 8'h13);
      ack(); src_req = 0; ret();
      cyc();

      // R8 nesting and R10 return order
      wr(1, 8'h08);
      src_req = 4'b0001;
      expect_vec("R8 low ext0", 8'h03);
      ack(); src_req = 4'b0010;
      expect_none("R8 low waits under low");
      src_req = 4'b1010;
      expect_vec("R8 high preempts low", 8'h1B);
      ack(); src_req = 4'b0010;
      ret();
      expect_none("R10 low still in service");
      src_req = 4'b1010;
      expect_vec("R10 high accepted again", 8'h1B);
      ack(); src_req = 4'b0010; ret();
      expect_none("R10 low remains after second high");
      ret();
      expect_vec("R10 low released", 8'h0B);
      ack(); src_req = 0; ret();
      repeat (3) cyc();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule